// File: doc/BRIEF.md
# Nested Priority Interrupt Masking Unit

This block sits between a set of level-sensitive interrupt request lines and a processor. It keeps a registered copy of the requests (the pending vector), a software-owned enable vector per source and a single global enable. It combines these to decide whether to raise the processor interrupt line, and it reports which source should be serviced. Among the enabled pending sources, a higher bit index always has the higher priority.

When the processor takes the interrupt with the accept strobe, the unit pushes the current enable vector onto a small save stack. It then narrows the live vector so that only sources of strictly higher priority than the accepted one can preempt the handler. Nesting is therefore allowed for more urgent sources only. The return strobe undoes one level in two steps. The edge that samples it drops the global enable, and the following edge reloads the enable vector from the top of the stack. An accept that finds the stack full is refused and recorded in a sticky error flag.

Software sees four word-wide registers through a simple write strobe and a combinational read port: the enable vector, a control word, the pending vector and the most recently saved vector.

Top module: `irq_nest_mask`

## Requirements
- R1: Every clock edge loads the pending vector from `irq_req_i`, so each pending bit follows its request line one cycle late. The pending vector reads back at address 2.
- R2: `cpu_irq_o` is 1 exactly when the global enable is 1 and (pending AND enable vector) is non-zero. With the global enable at 0 it stays 0 whatever is pending.
- R3: `sel_vld_o` is 1 when (pending AND enable vector) is non-zero, and `sel_idx_o` is then the binary index of its highest set bit. When the candidate set is empty, `sel_idx_o` is 0.
- R4: When `accept_i` is sampled while `cpu_irq_o` is 1 and the stack holds fewer than STACK_DEPTH entries, the enable vector is pushed. The vector is then cleared at the selected index and every lower index, and the stack depth grows by one.
- R5: `accept_i` sampled while `cpu_irq_o` is 0 changes neither the enable vector nor the stack depth.
- R6: An accept that would otherwise be taken while the stack already holds STACK_DEPTH entries sets the sticky error flag and leaves the enable vector and depth unchanged. The flag also drives `ovf_err_o`.
- R7: When `return_i` is taken, the global enable reads 0 after the edge that samples it. After the following edge, the enable vector equals the value that was on top of the stack, and the depth has dropped by one.
- R8: `return_i` is ignored when the stack is empty or when a restore is already in progress. When a return is taken, an `accept_i` sampled on the same edge is ignored.
- R9: A write to address 0 loads the enable vector, except on an edge where a restore or a successful push changes it. A write to address 1 loads the global enable from data bit 0, except on an edge where a return is taken. Writing 1 to data bit 1 at address 1 clears the error flag, unless the flag is being set on that edge.
- R10: `cfg_rdata_o` is combinational from `cfg_addr_i`. Address 0 returns the enable vector. Address 1 returns the global enable in bit 0, the error flag in bit 1 and the stack depth from bit 2 upward. Address 2 returns the pending vector. Address 3 returns the top stack entry, or 0 when the stack is empty.
- R11: After reset, all state is zero: pending, enable vector, global enable, error flag, stack depth and restore phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | N_SRC | Level-sensitive interrupt requests |
| accept_i | input | 1 | Processor takes the signalled interrupt |
| return_i | input | 1 | Handler finished, unwind one nesting level |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | N_SRC | Register write data |
| cfg_rdata_o | output | N_SRC | Register read data |
| cpu_irq_o | output | 1 | Interrupt line to the processor |
| sel_idx_o | output | $clog2(N_SRC) | Index of highest-priority candidate |
| sel_vld_o | output | 1 | Candidate set is non-empty |
| ovf_err_o | output | 1 | Sticky save-stack overflow flag |

## Verification
Single-bit and widely spread request patterns, including the extreme bits 0 and N_SRC-1, separate a correct leading-one search from one that favours the low end or drops an edge bit. A staircase of requests, each accepted in turn, nests the unit to full depth, where every level must leave exactly the bits above the accepted index. A further accept then exposes any overflow that corrupts the vector. The unwind sequence checks that each return restores the saved vectors in reverse order with the enable dropping one edge earlier. Same-cycle collisions (return with accept, push with a register write, restore with a register write, return with an enable write) tell apart the intended priorities from any other ordering.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

   typedef enum logic [1:0] {
      REG_MASK  = 2'd0,
      REG_CTRL  = 2'd1,
      REG_PEND  = 2'd2,
      REG_SAVED = 2'd3
   } nest_reg_e;

   localparam int CTRL_EN_BIT    = 0;
   localparam int CTRL_OVF_BIT   = 1;
   localparam int CTRL_DEPTH_LSB = 2;

endpackage

// File: rtl/irq_nest_prio.sv
module irq_nest_prio #(
   parameter int N_SRC = 8,
   localparam int IW   = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] cand_i,
   output logic [IW-1:0]    idx_o,
   output logic             vld_o,
   output logic [N_SRC-1:0] above_o
);

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (cand_i[i]) idx_o = IW'(i);
      end
   end

   assign vld_o = |cand_i;

   for (genvar g = 0; g < N_SRC; g++) begin : g_above
      assign above_o[g] = (IW'(g) > idx_o);
   end

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [W-1:0]  din_i,
   output logic [W-1:0]  top_o,
   output logic [CW-1:0] depth_o,
   output logic          full_o,
   output logic          empty_o
);

   logic [W-1:0]  slot_q [DEPTH];
   logic [CW-1:0] cnt_q;

   assign full_o  = (cnt_q == CW'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign depth_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (push_i && !full_o)        cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !empty_o)        cnt_q <= cnt_q - 1'b1;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  slot_q[g] <= '0;
         else if (push_i && cnt_q == CW'(g))          slot_q[g] <= din_i;
      end
   end

   always_comb begin
      top_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cnt_q == CW'(i + 1)) top_o = slot_q[i];
      end
   end

endmodule

// File: rtl/irq_nest_mask.sv
module irq_nest_mask
   import irq_nest_pkg::*;
#(
   parameter int N_SRC       = 8,
   parameter int STACK_DEPTH = 8,
   localparam int IW         = $clog2(N_SRC),
   localparam int CW         = $clog2(STACK_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_req_i,
   input  logic             accept_i,
   input  logic             return_i,
   input  logic             cfg_we_i,
   input  logic [1:0]       cfg_addr_i,
   input  logic [N_SRC-1:0] cfg_wdata_i,
   output logic [N_SRC-1:0] cfg_rdata_o,
   output logic             cpu_irq_o,
   output logic [IW-1:0]    sel_idx_o,
   output logic             sel_vld_o,
   output logic             ovf_err_o
);

   if (N_SRC < 2) begin : g_bad_src
      $error("irq_nest_mask: N_SRC must be at least 2");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("irq_nest_mask: STACK_DEPTH must be at least 1");
   end
   if (N_SRC < CTRL_DEPTH_LSB + CW) begin : g_bad_ctrl
      $error("irq_nest_mask: N_SRC too narrow for the control word");
   end

   logic [N_SRC-1:0] pend_q, mask_q, cand, above, saved_top;
   logic             en_q, ovf_q, rest_q;
   logic [CW-1:0]    depth;
   logic             stk_full, stk_empty;
   logic             ret_take, acc_try, push, ovf_set;
   logic             wr_mask, wr_ctrl;

   assign cand = pend_q & mask_q;

   irq_nest_prio #(.N_SRC(N_SRC)) u_prio (
      .cand_i  (cand),
      .idx_o   (sel_idx_o),
      .vld_o   (sel_vld_o),
      .above_o (above)
   );

   assign cpu_irq_o = en_q & sel_vld_o;
   assign ret_take  = return_i & ~stk_empty & ~rest_q;
   assign acc_try   = accept_i & cpu_irq_o & ~ret_take;
   assign push      = acc_try & ~stk_full;
   assign ovf_set   = acc_try & stk_full;
   assign wr_mask   = cfg_we_i & (cfg_addr_i == REG_MASK);
   assign wr_ctrl   = cfg_we_i & (cfg_addr_i == REG_CTRL);

   irq_nest_stack #(.W(N_SRC), .DEPTH(STACK_DEPTH)) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .pop_i   (rest_q),
      .din_i   (mask_q),
      .top_o   (saved_top),
      .depth_o (depth),
      .full_o  (stk_full),
      .empty_o (stk_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
         en_q   <= 1'b0;
         ovf_q  <= 1'b0;
         rest_q <= 1'b0;
      end else begin
         pend_q <= irq_req_i;
         rest_q <= ret_take;

         if (rest_q)       mask_q <= saved_top;
         else if (push)    mask_q <= mask_q & above;
         else if (wr_mask) mask_q <= cfg_wdata_i;

         if (ret_take)     en_q <= 1'b0;
         else if (wr_ctrl) en_q <= cfg_wdata_i[CTRL_EN_BIT];

         if (ovf_set)                                   ovf_q <= 1'b1;
         else if (wr_ctrl && cfg_wdata_i[CTRL_OVF_BIT]) ovf_q <= 1'b0;
      end
   end

   assign ovf_err_o = ovf_q;

   always_comb begin
      cfg_rdata_o = '0;
      unique case (nest_reg_e'(cfg_addr_i))
         REG_MASK:  cfg_rdata_o = mask_q;
         REG_CTRL: begin
            cfg_rdata_o[CTRL_EN_BIT]               = en_q;
            cfg_rdata_o[CTRL_OVF_BIT]              = ovf_q;
            cfg_rdata_o[CTRL_DEPTH_LSB +: CW]      = depth;
         end
         REG_PEND:  cfg_rdata_o = pend_q;
         REG_SAVED: cfg_rdata_o = saved_top;
         default:   cfg_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/irq_nest_mask_chk.sv
module irq_nest_mask_chk #(
   parameter int N_SRC       = 8,
   parameter int STACK_DEPTH = 8,
   localparam int IW         = $clog2(N_SRC),
   localparam int CW         = $clog2(STACK_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             accept_i,
   input logic             return_i,
   input logic             cfg_we_i,
   input logic [1:0]       cfg_addr_i,
   input logic [N_SRC-1:0] cfg_wdata_i,
   input logic             cpu_irq_o,
   input logic [IW-1:0]    sel_idx_o,
   input logic             sel_vld_o,
   input logic             ovf_err_o,
   input logic             en_q,
   input logic             rest_q,
   input logic [N_SRC-1:0] pend_q,
   input logic [N_SRC-1:0] mask_q,
   input logic [N_SRC-1:0] saved_top,
   input logic [CW-1:0]    depth
);

   // R2: no interrupt reaches the processor while globally disabled
   p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !cpu_irq_o);

   // R3: the reported index is a live candidate
   p_sel_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_vld_o |-> (pend_q[sel_idx_o] && mask_q[sel_idx_o]));

   // R4: an accepted interrupt only ever removes bits, including its own
   p_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && cpu_irq_o && !return_i && depth < CW'(STACK_DEPTH))
      |=> (((mask_q & ~$past(mask_q)) == '0) && !mask_q[$past(sel_idx_o)]
           && depth == $past(depth) + 1'b1));

   // R4: depth never exceeds the stack size
   p_depth_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= CW'(STACK_DEPTH));

   // R6: the overflow flag holds until explicitly cleared
   p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_err_o && !(cfg_we_i && cfg_addr_i == 2'd1 && cfg_wdata_i[1]))
      |=> ovf_err_o);

   // R7: a taken return drops the enable on the next edge
   p_ret_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (return_i && depth != '0 && !rest_q) |=> (!en_q && rest_q));

   // R7: the restore phase reloads the saved vector and pops one entry
   p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rest_q |=> (mask_q == $past(saved_top) && depth == $past(depth) - 1'b1));

endmodule

bind irq_nest_mask irq_nest_mask_chk #(
   .N_SRC       (N_SRC),
   .STACK_DEPTH (STACK_DEPTH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .accept_i    (accept_i),
   .return_i    (return_i),
   .cfg_we_i    (cfg_we_i),
   .cfg_addr_i  (cfg_addr_i),
   .cfg_wdata_i (cfg_wdata_i),
   .cpu_irq_o   (cpu_irq_o),
   .sel_idx_o   (sel_idx_o),
   .sel_vld_o   (sel_vld_o),
   .ovf_err_o   (ovf_err_o),
   .en_q        (en_q),
   .rest_q      (rest_q),
   .pend_q      (pend_q),
   .mask_q      (mask_q),
   .saved_top   (saved_top),
   .depth       (depth)
);

// File: tb/tb_irq_nest_mask.sv
`timescale 1ns/1ps
module tb_irq_nest_mask;

   localparam int N = 8;
   localparam int D = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq = '0;
   logic         ack = 1'b0, ret = 1'b0, we = 1'b0;
   logic [1:0]   addr = 2'd0;
   logic [N-1:0] wdata = '0;
   logic [N-1:0] rdata;
   logic         cpu_irq, sel_vld, ovf;
   logic [2:0]   sel_idx;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   irq_nest_mask #(.N_SRC(N), .STACK_DEPTH(D)) dut (
      .clk(clk), .rst_n(rst_n), .irq_req_i(irq), .accept_i(ack), .return_i(ret),
      .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
      .cpu_irq_o(cpu_irq), .sel_idx_o(sel_idx), .sel_vld_o(sel_vld), .ovf_err_o(ovf)
   );

   // behavioural reference
   logic [N-1:0] m_pend = '0, m_mask = '0;
   bit           m_en = 0, m_ovf = 0, m_rest = 0;
   logic [N-1:0] m_stk[$];
   string        cur_req = "R11";

   function automatic int top_idx(logic [N-1:0] c);
      int r = 0;
      for (int i = 0; i < N; i++) if (c[i]) r = i;
      return r;
   endfunction

   function automatic logic [N-1:0] m_read(logic [1:0] a);
      case (a)
         2'd0: return m_mask;
         2'd1: return {2'b00, 4'(m_stk.size()), 1'(m_ovf), 1'(m_en)};
         2'd2: return m_pend;
         default: return (m_stk.size() > 0) ? m_stk[m_stk.size()-1] : '0;
      endcase
   endfunction

   task automatic model_step();
      logic [N-1:0] cand = m_pend & m_mask;
      bit irqo = m_en && (cand != 0);
      int idx  = top_idx(cand);
      bit rt   = ret && (m_stk.size() > 0) && !m_rest;
      bit at   = ack && irqo && !rt;
      bit full = (m_stk.size() == D);
      logic [N-1:0] nm = m_mask;
      bit n_en = m_en, n_ovf = m_ovf;
      if (m_rest) nm = m_stk.pop_back();
      else if (at && !full) begin
         m_stk.push_back(m_mask);
         nm = m_mask & ~N'((1 << (idx + 1)) - 1);
      end else if (we && addr == 2'd0) nm = wdata;
      if (rt) n_en = 0; else if (we && addr == 2'd1) n_en = wdata[0];
      if (at && full) n_ovf = 1; else if (we && addr == 2'd1 && wdata[1]) n_ovf = 0;
      m_mask = nm; m_en = n_en; m_ovf = n_ovf; m_rest = rt; m_pend = irq;
   endtask

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [N-1:0] cand = m_pend & m_mask;
      chk("R2", cpu_irq, m_en && (cand != 0));
      chk("R3", sel_vld, cand != 0);
      chk("R3", sel_idx, (cand != 0) ? top_idx(cand) : 0);
      chk(cur_req, rdata, m_read(addr));
      chk("R6", ovf, m_ovf);
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic wr(logic [1:0] a, logic [N-1:0] d);
      we = 1; addr = a; wdata = d; cyc(); we = 0;
   endtask

   task automatic rd(string req, logic [1:0] a, int exp);
      addr = a; #1; chk(req, rdata, exp);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      // R11: reset state
      chk("R11", cpu_irq, 0); chk("R11", sel_vld, 0); chk("R11", sel_idx, 0);
      for (int a = 0; a < 4; a++) rd("R11", 2'(a), 0);
      rst_n = 1;
      cyc();

      // R1: pending follows requests one cycle late
      cur_req = "R1";
      irq = 8'h5A; addr = 2'd2; cyc();
      rd("R1", 2'd2, 8'h5A);
      irq = 8'h81; cyc(); rd("R1", 2'd2, 8'h81);

      // R2 / R3: gating and leading-one search
      cur_req = "R10";
      wr(2'd0, 8'hFF);
      irq = 8'h24; cyc();
      chk("R2", cpu_irq, 0); chk("R3", sel_idx, 5); chk("R3", sel_vld, 1);
      wr(2'd1, 8'h01);
      chk("R2", cpu_irq, 1);
      irq = 8'h81; cyc(); chk("R3", sel_idx, 7);
      wr(2'd0, 8'h7F); chk("R3", sel_idx, 0);
      irq = 8'h00; cyc(); chk("R3", sel_vld, 0); chk("R2", cpu_irq, 0);

      // R5: accept without an interrupt is ignored
      cur_req = "R5";
      irq = 8'h24; wr(2'd1, 8'h00);
      ack = 1; cyc(); ack = 0;
      rd("R5", 2'd1, 8'h00); rd("R5", 2'd0, 8'h7F);

      // R4: nest to full depth with a staircase
      cur_req = "R4";
      wr(2'd0, 8'hFF); wr(2'd1, 8'h01);
      for (int k = 0; k < D; k++) begin
         irq = N'((1 << (k + 1)) - 1); cyc();
         chk("R4", sel_idx, k);
         ack = 1; cyc(); ack = 0;
         rd("R4", 2'd0, N'(8'hFF << (k + 1)));
         rd("R4", 2'd1, ((k + 1) << 2) | 1);
      end

      // R6: overflow refused and flagged
      cur_req = "R6";
      wr(2'd0, 8'h80); irq = 8'h80; cyc();
      chk("R6", cpu_irq, 1);
      ack = 1; cyc(); ack = 0;
      rd("R6", 2'd1, 8'h23); rd("R6", 2'd0, 8'h80); chk("R6", ovf, 1);

      // R8: return beats accept; R7: two-step unwind
      cur_req = "R8";
      ack = 1; ret = 1; cyc(); ack = 0; ret = 0;
      rd("R7", 2'd1, 8'h22); rd("R7", 2'd0, 8'h80);
      cyc();
      rd("R7", 2'd0, 8'h80); rd("R7", 2'd1, 8'h1E);
      ret = 1; cyc(); cyc(); ret = 0;   // second return falls in restore phase
      rd("R8", 2'd1, 8'h1A); rd("R8", 2'd0, 8'hC0);
      cur_req = "R7";
      for (int k = 5; k >= 0; k--) begin
         ret = 1; cyc(); ret = 0; cyc();
         rd("R7", 2'd0, N'(8'hFF << k));
      end
      rd("R7", 2'd1, 8'h02);
      wr(2'd1, 8'h01);
      ret = 1; cyc(); ret = 0;
      rd("R8", 2'd1, 8'h03);

      // R9: clear overflow and write collisions
      cur_req = "R9";
      wr(2'd1, 8'h03); rd("R9", 2'd1, 8'h01); chk("R9", ovf, 0);
      wr(2'd0, 8'hFF); irq = 8'h10; cyc();
      ack = 1; we = 1; addr = 2'd0; wdata = 8'h0F; cyc(); ack = 0; we = 0;
      rd("R9", 2'd0, 8'hE0); rd("R9", 2'd3, 8'hFF);
      ret = 1; we = 1; addr = 2'd1; wdata = 8'h01; cyc(); ret = 0;
      rd("R9", 2'd1, 8'h04);
      we = 1; addr = 2'd0; wdata = 8'h33; cyc(); we = 0;
      rd("R9", 2'd0, 8'hFF); rd("R9", 2'd1, 8'h00); rd("R10", 2'd3, 8'h00);
      irq = 8'h00; cyc(); cyc();

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule